// File: doc/BRIEF.md
# Spindle Drive Mode and Brake Controller

This block chooses how a three-phase spindle motor is driven from one 12-bit two's-complement speed command and the rotor speed it measures for itself. The three phase-detect bits are folded by exclusive-OR into a single FG level. That level drives the FG output pin. Its falling edges time one FG period, which gives a fast/slow speed decision with hysteresis. A second counter notices when FG has sat low long enough that the rotor can be taken as stopped.

From the command, the speed decision, the stall flag, a low-speed-mode bit and a sleep bit, the controller selects one of six drive modes and a PWM duty magnitude. Both are registered, so they change one clock after their inputs. All time windows are counted in clock cycles and set by parameters. The defaults assume a 1 MHz tick: 833 cycles is about 3000 rpm and 1250 cycles about 2000 rpm on a 16-pole motor with 24 FG periods per turn, and 300000 cycles is the 300 ms stall window.

Top module: `spindle_mode_ctrl`

## Requirements
- R1: When sleep is low, `fg_pin` equals the XOR of the three `phase_in` bits as sampled at the previous rising clock edge.
- R2: When sleep is high, `fg_pin` is high in the same cycle. One clock later `mode` is idle (0) and `duty` is 0, for any command.
- R3: A command value from 0 to +82 gives mode idle (0) with duty 0. A value above +82 gives mode accelerate (1) with duty = min(255, (value − 82) >> 2). Both results appear one clock after the input.
- R4: A command value from −1 to −82 (codes 0xFFF down to 0xFAE) gives mode two-phase short brake (3) with duty 0.
- R5: A command value from −83 to −1535 (codes 0xFAD down to 0xA01) gives mode active brake (2) with duty = min(255, (|value| − 82) >> 2).
- R6: A command value from −1536 to −2048 (codes 0xA00 down to 0x800) gives mode three-phase short brake (4) with duty 0 while the speed flag is set. Otherwise it gives active brake with the R5 duty formula.
- R7: The speed flag sets when a falling-edge-to-falling-edge FG period shorter than FAST_PERIOD cycles is measured. It clears when a measured period exceeds SLOW_PERIOD cycles, or when more than SLOW_PERIOD cycles pass with no falling edge. A period between the two limits leaves the flag unchanged. The first falling edge after reset only starts timing.
- R8: If FG has stayed low for STALL_CYCLES consecutive cycles and the command is a brake request (value below −82), mode becomes stop (5) with duty 0. This takes priority over the low-speed and range rules. A positive command is not affected.
- R9: With low-speed mode set, every brake request outside the dead band gives two-phase short brake (3) with duty 0, and the accelerate duty is capped at 63.
- R10: During and directly after reset, `mode` is idle (0), `duty` is 0 and `fg_pin` is low while sleep is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| cmd_code | input | 12 | Speed command, two's complement |
| phase_in | input | 3 | Rotor phase-detect bits |
| low_speed | input | 1 | Low-speed mode select |
| sleep | input | 1 | Sleep select |
| mode | output | 3 | Drive mode: 0 idle, 1 accelerate, 2 active brake, 3 two-phase short, 4 three-phase short, 5 stop |
| duty | output | 8 | PWM duty magnitude, 255 = 100 % |
| fg_pin | output | 1 | FG level, forced high in sleep |

## Verification
`mode` and `duty` are due one clock after a command, low-speed or sleep change. `fg_pin` is due one clock after a phase change, and in the same cycle after a sleep change. The bench drives every input on a falling clock edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and check. The speed and stall decisions need many cycles. For those, the bench holds a steady FG period for several periods, or holds FG low for a counted number of cycles, and then checks well inside the window rather than at its exact edge. The random phase stimulus uses only odd-parity patterns, so FG stays high and the speed and stall flags are known to be clear.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [2:0] {
    MD_IDLE   = 3'd0,
    MD_ACCEL  = 3'd1,
    MD_ACTIVE = 3'd2,
    MD_SHORT2 = 3'd3,
    MD_SHORT3 = 3'd4,
    MD_STOP   = 3'd5
  } spm_mode_e;
endpackage

// File: rtl/spm_fg_gen.sv
module spm_fg_gen #(
  parameter int PHASES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] phase_in,
  input  logic              sleep,
  output logic              fg_level,
  output logic              fg_fall,
  output logic              fg_pin
);
  logic fg_q, fg_d1, armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      fg_q  <= 1'b0;
      fg_d1 <= 1'b0;
      armed <= 1'b0;
    end else begin
      fg_q  <= ^phase_in;
      fg_d1 <= fg_q;
      armed <= 1'b1;
    end
  end

  assign fg_level = fg_q;
  assign fg_fall  = fg_d1 & ~fg_q;
  assign fg_pin   = sleep | fg_q;

  // R1: registered FG follows the phase parity of the previous edge
  a_r1_fg_follows_xor: assert property (@(posedge clk) disable iff (rst)
    (armed && !sleep) |-> (fg_pin == $past(^phase_in)));

  // R1: a falling-edge pulse lasts exactly one cycle
  a_r1_fall_single: assert property (@(posedge clk) disable iff (rst)
    fg_fall |=> !fg_fall);
endmodule

// File: rtl/spm_speed_meter.sv
module spm_speed_meter #(
  parameter int FAST_PERIOD  = 833,
  parameter int SLOW_PERIOD  = 1250,
  parameter int STALL_CYCLES = 300000
) (
  input  logic clk,
  input  logic rst,
  input  logic fg_level,
  input  logic fg_fall,
  output logic fast,
  output logic stall
);
  localparam int PER_MAX = SLOW_PERIOD + 1;
  localparam int PER_W   = $clog2(PER_MAX + 1);
  localparam int STL_W   = $clog2(STALL_CYCLES + 1);

  logic [PER_W-1:0] per_cnt;
  logic [STL_W-1:0] low_cnt;
  logic             seen, fast_q;

  // period counter and speed flag with hysteresis
  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= '0;
      seen    <= 1'b0;
      fast_q  <= 1'b0;
    end else if (fg_fall) begin
      per_cnt <= PER_W'(1);
      seen    <= 1'b1;
      if (seen) begin
        if (per_cnt < PER_W'(FAST_PERIOD))
          fast_q <= 1'b1;
        else if (per_cnt > PER_W'(SLOW_PERIOD))
          fast_q <= 1'b0;
      end
    end else begin
      if (per_cnt != PER_W'(PER_MAX))
        per_cnt <= per_cnt + 1'b1;
      else
        fast_q <= 1'b0;
    end
  end

  // consecutive-low counter for stall detection
  always_ff @(posedge clk) begin
    if (rst)
      low_cnt <= '0;
    else if (fg_level)
      low_cnt <= '0;
    else if (low_cnt != STL_W'(STALL_CYCLES))
      low_cnt <= low_cnt + 1'b1;
  end

  assign fast  = fast_q;
  assign stall = (low_cnt == STL_W'(STALL_CYCLES));

  // R7: the speed flag can only rise right after a falling FG edge
  a_r7_fast_rises_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(fast) |-> $past(fg_fall));

  // R7: a gap longer than the slow limit leaves the flag clear
  a_r7_gap_clears: assert property (@(posedge clk) disable iff (rst)
    (per_cnt == PER_W'(PER_MAX) && !fg_fall) |=> !fast);

  // R8: stall is only reported after FG was low
  a_r8_stall_needs_low: assert property (@(posedge clk) disable iff (rst)
    stall |-> $past(!fg_level));
endmodule

// File: rtl/spm_mode_sel.sv
module spm_mode_sel
  import spm_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int DUTY_W      = 8,
  parameter int DEAD_BAND   = 82,
  parameter int STRONG_EDGE = 1536,
  parameter int DUTY_SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              low_speed,
  input  logic              sleep,
  input  logic              fast,
  input  logic              stall,
  output logic [2:0]        mode_o,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int FULL   = (1 << DUTY_W) - 1;
  localparam int LS_CAP = FULL >> 2;

  function automatic int code_value(input logic [CODE_W-1:0] c);
    return int'($signed(c));
  endfunction

  function automatic logic [DUTY_W-1:0] scale_duty(input int mag, input logic cap);
    int d;
    d = (mag - DEAD_BAND) >>> DUTY_SHIFT;
    if (d < 0) d = 0;
    if (d > FULL) d = FULL;
    if (cap && d > LS_CAP) d = LS_CAP;
    return d[DUTY_W-1:0];
  endfunction

  int                cmd_v;
  spm_mode_e         nxt_mode, mode_q;
  logic [DUTY_W-1:0] nxt_duty, duty_q;

  always_comb begin
    cmd_v    = code_value(cmd_code);
    nxt_mode = MD_IDLE;
    nxt_duty = '0;
    if (sleep) begin
      nxt_mode = MD_IDLE;
    end else if (cmd_v > DEAD_BAND) begin
      nxt_mode = MD_ACCEL;
      nxt_duty = scale_duty(cmd_v, low_speed);
    end else if (cmd_v >= -DEAD_BAND) begin
      nxt_mode = (cmd_v >= 0) ? MD_IDLE : MD_SHORT2;
    end else if (stall) begin
      nxt_mode = MD_STOP;
    end else if (low_speed) begin
      nxt_mode = MD_SHORT2;
    end else if (cmd_v > -STRONG_EDGE || !fast) begin
      nxt_mode = MD_ACTIVE;
      nxt_duty = scale_duty(-cmd_v, 1'b0);
    end else begin
      nxt_mode = MD_SHORT3;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_IDLE;
      duty_q <= '0;
    end else begin
      mode_q <= nxt_mode;
      duty_q <= nxt_duty;
    end
  end

  assign mode_o = mode_q;
  assign duty_o = duty_q;

  // R2: sleep forces idle with zero duty one cycle later
  a_r2_sleep_idle: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (mode_o == 3'd0 && duty_o == '0));

  // R6: three-phase short brake only while the speed flag was set
  a_r6_short3_needs_fast: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |-> $past(fast));

  // R8: stop only follows a reported stall
  a_r8_stop_needs_stall: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd5) |-> $past(stall));

  // R9: low-speed mode caps the duty
  a_r9_ls_cap: assert property (@(posedge clk) disable iff (rst)
    low_speed |=> (duty_o <= DUTY_W'(LS_CAP)));
endmodule

// File: rtl/spindle_mode_ctrl.sv
module spindle_mode_ctrl #(
  parameter int CODE_W       = 12,
  parameter int DUTY_W       = 8,
  parameter int PHASES       = 3,
  parameter int DEAD_BAND    = 82,
  parameter int STRONG_EDGE  = 1536,
  parameter int DUTY_SHIFT   = 2,
  parameter int FAST_PERIOD  = 833,
  parameter int SLOW_PERIOD  = 1250,
  parameter int STALL_CYCLES = 300000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [PHASES-1:0] phase_in,
  input  logic              low_speed,
  input  logic              sleep,
  output logic [2:0]        mode,
  output logic [DUTY_W-1:0] duty,
  output logic              fg_pin
);
  logic fg_level, fg_fall, spd_fast, spd_stall;

  spm_fg_gen #(.PHASES(PHASES)) u_fg (
    .clk(clk), .rst(rst), .phase_in(phase_in), .sleep(sleep),
    .fg_level(fg_level), .fg_fall(fg_fall), .fg_pin(fg_pin)
  );

  spm_speed_meter #(
    .FAST_PERIOD(FAST_PERIOD), .SLOW_PERIOD(SLOW_PERIOD),
    .STALL_CYCLES(STALL_CYCLES)
  ) u_spd (
    .clk(clk), .rst(rst), .fg_level(fg_level), .fg_fall(fg_fall),
    .fast(spd_fast), .stall(spd_stall)
  );

  spm_mode_sel #(
    .CODE_W(CODE_W), .DUTY_W(DUTY_W), .DEAD_BAND(DEAD_BAND),
    .STRONG_EDGE(STRONG_EDGE), .DUTY_SHIFT(DUTY_SHIFT)
  ) u_sel (
    .clk(clk), .rst(rst), .cmd_code(cmd_code), .low_speed(low_speed),
    .sleep(sleep), .fast(spd_fast), .stall(spd_stall),
    .mode_o(mode), .duty_o(duty)
  );

  // R10: outputs held at rest during reset
  a_r10_reset_rest: assert property (@(posedge clk)
    $past(rst) |-> (mode == 3'd0 && duty == '0));
endmodule

// File: tb/sim_spindle_mode_ctrl.sv
module sim_spindle_mode_ctrl;
  localparam int FASTP = 40;
  localparam int SLOWP = 60;
  localparam int STALLC = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cmd_code = 12'h000;
  logic [2:0]  phase_in = 3'b001;
  logic        low_speed = 1'b0;
  logic        sleep = 1'b0;
  logic [2:0]  mode;
  logic [7:0]  duty;
  logic        fg_pin;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spindle_mode_ctrl #(
    .FAST_PERIOD(FASTP), .SLOW_PERIOD(SLOWP), .STALL_CYCLES(STALLC)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_code(cmd_code), .phase_in(phase_in),
    .low_speed(low_speed), .sleep(sleep), .mode(mode), .duty(duty),
    .fg_pin(fg_pin)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // expected mode and duty computed from the requirement text
  function automatic void ref_out(input logic [11:0] c, input bit ls, input bit sl,
                                  input bit fst, input bit stl,
                                  output int m, output int d);
    int s, mag, raw;
    s = c[11] ? int'(c) - 4096 : int'(c);
    mag = (s < 0) ? -s : s;
    raw = (mag > 82) ? (mag - 82) / 4 : 0;
    if (raw > 255) raw = 255;
    m = 0; d = 0;
    if (sl) return;
    if (s > 82) begin
      m = 1; d = (ls && raw > 63) ? 63 : raw;
    end else if (s >= 0) m = 0;
    else if (s >= -82) m = 3;
    else if (stl) m = 5;
    else if (ls) m = 3;
    else if (s <= -1536 && fst) m = 4;
    else begin m = 2; d = raw; end
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_cmd(input string req, input logic [11:0] c, input bit ls, input bit sl,
                           input bit fst, input bit stl);
    int em, ed;
    cmd_code = c; low_speed = ls; sleep = sl;
    step(1);
    ref_out(c, ls, sl, fst, stl, em, ed);
    chk({req, " mode"}, int'(mode), em);
    chk({req, " duty"}, int'(duty), ed);
  endtask

  task automatic spin(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      phase_in = 3'b001; step(p / 2);
      phase_in = 3'b000; step(p - p / 2);
    end
    phase_in = 3'b001; step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all requirements) got=hang exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] odd_pat [4];
    int unsigned r;
    odd_pat[0] = 3'b001; odd_pat[1] = 3'b010; odd_pat[2] = 3'b100; odd_pat[3] = 3'b111;
    r = $urandom(32'd4321);

    step(3);
    // R10 reset state
    chk("R10 mode in reset", int'(mode), 0);
    chk("R10 duty in reset", int'(duty), 0);
    chk("R10 fg_pin in reset", int'(fg_pin), 0);
    rst = 1'b0;
    step(1);
    chk("R10 mode after reset", int'(mode), 0);
    chk("R1 fg after reset", int'(fg_pin), 1);

    // directed range corners, speed flag clear, FG held high
    check_cmd("R3 zero", 12'h000, 0, 0, 0, 0);
    check_cmd("R3 dead band top", 12'h052, 0, 0, 0, 0);
    check_cmd("R3 first accel", 12'h053, 0, 0, 0, 0);
    check_cmd("R3 mid accel", 12'h0A0, 0, 0, 0, 0);
    check_cmd("R3 full accel", 12'h7FF, 0, 0, 0, 0);
    check_cmd("R4 minus one", 12'hFFF, 0, 0, 0, 0);
    check_cmd("R4 dead band edge", 12'hFAE, 0, 0, 0, 0);
    check_cmd("R5 first active", 12'hFAD, 0, 0, 0, 0);
    check_cmd("R5 mid active", 12'hF00, 0, 0, 0, 0);
    check_cmd("R5 last active", 12'hA01, 0, 0, 0, 0);
    check_cmd("R6 strong edge slow", 12'hA00, 0, 0, 0, 0);
    check_cmd("R6 strongest slow", 12'h800, 0, 0, 0, 0);
    check_cmd("R9 ls accel cap", 12'h7FF, 1, 0, 0, 0);
    check_cmd("R9 ls brake", 12'hF00, 1, 0, 0, 0);
    check_cmd("R9 ls small accel", 12'h0A0, 1, 0, 0, 0);
    check_cmd("R2 sleep", 12'h400, 0, 1, 0, 0);
    chk("R2 fg_pin sleep", int'(fg_pin), 1);

    // random commands, FG kept high so speed and stall flags stay clear
    for (int i = 0; i < 300; i++) begin
      logic [11:0] c;
      int cat;
      cat = int'($urandom_range(0, 3));
      case (cat)
        0: c = 12'($urandom_range(0, 200));
        1: c = 12'(4096 - int'($urandom_range(1, 200)));
        default: c = 12'($urandom);
      endcase
      phase_in = odd_pat[$urandom_range(0, 3)];
      check_cmd("R3/R4/R5/R6/R9 random", c, 1'($urandom_range(0, 1)),
                ($urandom_range(0, 9) == 0), 0, 0);
    end
    sleep = 1'b0; low_speed = 1'b0;

    // R1 sweep of all phase patterns
    cmd_code = 12'h000;
    for (int p = 0; p < 8; p++) begin
      phase_in = 3'(p);
      step(1);
      chk("R1 fg xor", int'(fg_pin), int'(^phase_in));
    end
    sleep = 1'b1; phase_in = 3'b000; step(1);
    chk("R2 fg forced high", int'(fg_pin), 1);
    sleep = 1'b0; step(1);
    chk("R1 fg low after sleep", int'(fg_pin), 0);

    // R6 and R7: speed hysteresis under strongest brake
    cmd_code = 12'h900;
    spin(20, 6);
    chk("R7 fast period short brake3", int'(mode), 4);
    chk("R6 short brake3 duty", int'(duty), 0);
    spin(50, 4);
    chk("R7 middle period holds set", int'(mode), 4);
    spin(80, 4);
    chk("R7 slow period clears", int'(mode), 2);
    chk("R6 active duty", int'(duty), 255);
    spin(50, 4);
    chk("R7 middle period holds clear", int'(mode), 2);
    spin(30, 4);
    chk("R7 fast again", int'(mode), 4);
    low_speed = 1'b1;
    spin(20, 4);
    chk("R9 ls brake while fast", int'(mode), 3);
    chk("R9 ls brake duty", int'(duty), 0);
    low_speed = 1'b0;
    cmd_code = 12'hF00;
    spin(20, 2);
    chk("R5 active ignores fast", int'(mode), 2);
    chk("R5 active duty", int'(duty), 43);

    // R8 stall
    cmd_code = 12'h900;
    phase_in = 3'b000;
    step(STALLC - 20);
    chk("R8 before stall window", int'(mode), 2);
    step(40);
    chk("R8 stop", int'(mode), 5);
    chk("R8 stop duty", int'(duty), 0);
    low_speed = 1'b1; step(1);
    chk("R8 stop beats low speed", int'(mode), 5);
    low_speed = 1'b0;
    check_cmd("R8 positive not stopped", 12'h100, 0, 0, 0, 1);
    check_cmd("R8 dead band not stopped", 12'hFC0, 0, 0, 0, 1);
    cmd_code = 12'hF00; step(1);
    chk("R8 stop any brake", int'(mode), 5);
    phase_in = 3'b001; step(4);
    chk("R8 stall released", int'(mode), 2);
    chk("R8 released duty", int'(duty), 43);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule